// File: doc/BRIEF.md
# Load/Store Issue and Retry Controller

This block sits between an in-order stream of memory instructions and the request port of a data cache. Translated accesses enter an issue queue. From its head they move, always in program order, into a transfer queue where they wait to be committed. A cacheable load may go to the cache at once, while it is still speculative. A cacheable store never goes to the cache at this stage: it passes straight into the transfer queue, marked for the store buffer. A request whose predicate failed does the same, so that commit order is kept. Any other access (uncacheable, special) waits at the head of the issue queue until it is no longer speculative.

The cache may reject a request. The port then enters a retry state and presents nothing until a retry pulse arrives. After the pulse it presents the same held request again. Non-normal accesses in the memory system are counted against a limit. A register holds the sequence number of the most recent barrier.

Requests enter over a valid/ready handshake: a request moves only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` depends only on issue-queue occupancy. On the cache side `mem_ready` low while `mem_valid` is high is a rejection, not a stall. The commit side offers one entry (`cmt_valid`) and holds it until `cmt_pop`.

Top module: `lsq_issue_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_valid`, `cmt_valid` and `retry_pending` are 0. `last_barrier` is 0.
- R2: A request is taken only when the issue queue has a free entry. With IQ_DEPTH entries held, `req_ready` is 0.
- R3: The access kind is encoded as 0 cacheable load, 1 cacheable store, 2 other, 3 predicate failed. A kind-0 head is presented on the memory port (`mem_kind`=0, `mem_tag` = transfer slot) without waiting to become non-speculative. It becomes committable only after `resp_valid` returns its tag.
- R4: Kind 1 and kind 3 requests move to the transfer queue without any memory request, already complete. `cmt_to_sb` is 1 only for kind 1.
- R5: A kind-2 request is presented to memory only while `head_seq` equals its sequence number and `cur_stream` equals its stream number.
- R6: No kind-2 request is presented while MAX_INFLIGHT kind-2 accesses are issued and not yet answered.
- R7: A request that sees `mem_ready` low sets `retry_pending` on the next cycle. `mem_valid` then stays 0 until a `mem_retry` pulse. After that pulse the same request is presented again before any later one.
- R8: Commit entries leave in request order. `cmt_valid` is 1 only when the oldest transfer entry is complete, and that entry stays offered, unchanged, until `cmt_pop`.
- R9: `barrier_set` loads `last_barrier`. `barrier_done` clears it only when its sequence number equals the stored value; `barrier_set` wins if both arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Issue queue can take a request |
| req_kind | input | 2 | Access kind (see R3) |
| req_seq | input | SEQ_W | Instruction sequence number |
| req_stream | input | STREAM_W | Stream sequence number |
| head_seq | input | SEQ_W | Sequence number of the oldest in-flight memory instruction |
| cur_stream | input | STREAM_W | Current stream sequence number |
| mem_valid | output | 1 | Request presented to the cache |
| mem_ready | input | 1 | Cache accepts; low means reject |
| mem_kind | output | 2 | Kind of the presented request |
| mem_seq | output | SEQ_W | Sequence number of the presented request |
| mem_tag | output | TAG_W | Transfer slot used as response tag |
| mem_retry | input | 1 | Cache asks for the rejected request again |
| resp_valid | input | 1 | Memory response |
| resp_tag | input | TAG_W | Tag of the response |
| cmt_valid | output | 1 | Oldest transfer entry is committable |
| cmt_pop | input | 1 | Remove the offered entry |
| cmt_kind | output | 2 | Kind of the offered entry |
| cmt_seq | output | SEQ_W | Sequence number of the offered entry |
| cmt_to_sb | output | 1 | Offered entry is a store for the store buffer |
| barrier_set | input | 1 | A barrier was issued |
| barrier_set_seq | input | SEQ_W | Its sequence number |
| barrier_done | input | 1 | A barrier completed |
| barrier_done_seq | input | SEQ_W | Its sequence number |
| last_barrier | output | SEQ_W | Most recent barrier, 0 when none |
| retry_pending | output | 1 | Port is waiting for a retry |

## Verification
The bench goes after an uncacheable access sitting at the queue head with only its instruction number matching, or only its stream matching. A design that skipped either comparison would present it early. It holds responses back to fill the in-flight limit, and an off-by-one design would let a third access out. It rejects a load with a store queued behind it. A design that forgot the held request, or let the store overtake it, would break commit order or present while waiting. It also parks a finished store behind an unanswered load and withholds the pop. Checking only completion rather than head position, or dropping the entry without a pop, would show up there.

// File: rtl/lsq_ctrl_pkg.sv
package lsq_ctrl_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_OTHER = 2'd2,
    ACC_NOP   = 2'd3
  } acc_kind_e;

  typedef enum logic {
    PORT_RUN  = 1'b0,
    PORT_WAIT = 1'b1
  } port_state_e;
endpackage

// File: rtl/lsq_ring.sv
module lsq_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 4
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= din;
  end

  assign dout  = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/lsq_xfer_queue.sv
module lsq_xfer_queue #(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 4,
  parameter int TAG_W = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [1:0]       push_kind,
  input  logic             push_done,
  input  logic             push_counted,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             mark,
  input  logic [TAG_W-1:0] mark_tag,
  output logic             mark_counted,
  input  logic             pop,
  output logic [SEQ_W-1:0] head_seq,
  output logic [1:0]       head_kind,
  output logic             head_done,
  output logic             empty,
  output logic             full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] seq_q   [DEPTH];
  logic [1:0]       kind_q  [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] cnted_q;
  logic [TAG_W-1:0] wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
      cnted_q <= '0;
    end else begin
      if (push) begin
        done_q[wr_q]  <= push_done;
        cnted_q[wr_q] <= push_counted;
        wr_q          <= step(wr_q);
      end
      if (mark) done_q[mark_tag] <= 1'b1;
      if (pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      seq_q[wr_q]  <= push_seq;
      kind_q[wr_q] <= push_kind;
    end
  end

  assign alloc_tag    = wr_q;
  assign mark_counted = cnted_q[mark_tag];
  assign head_seq     = seq_q[rd_q];
  assign head_kind    = kind_q[rd_q];
  assign head_done    = done_q[rd_q];
  assign empty        = (cnt_q == '0);
  assign full         = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/lsq_barrier_reg.sv
module lsq_barrier_reg #(
  parameter int SEQ_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [SEQ_W-1:0] set_seq,
  input  logic             done,
  input  logic [SEQ_W-1:0] done_seq,
  output logic [SEQ_W-1:0] last
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        last <= '0;
    else if (set)                      last <= set_seq;
    else if (done && done_seq == last) last <= '0;
  end
endmodule

// File: rtl/lsq_issue_ctrl.sv
module lsq_issue_ctrl
  import lsq_ctrl_pkg::*;
#(
  parameter int SEQ_W        = 8,
  parameter int STREAM_W     = 4,
  parameter int IQ_DEPTH     = 4,
  parameter int XQ_DEPTH     = 4,
  parameter int MAX_INFLIGHT = 2,
  localparam int TAG_W = (XQ_DEPTH > 1) ? $clog2(XQ_DEPTH) : 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [SEQ_W-1:0]    req_seq,
  input  logic [STREAM_W-1:0] req_stream,
  input  logic [SEQ_W-1:0]    head_seq,
  input  logic [STREAM_W-1:0] cur_stream,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [1:0]          mem_kind,
  output logic [SEQ_W-1:0]    mem_seq,
  output logic [TAG_W-1:0]    mem_tag,
  input  logic                mem_retry,
  input  logic                resp_valid,
  input  logic [TAG_W-1:0]    resp_tag,
  output logic                cmt_valid,
  input  logic                cmt_pop,
  output logic [1:0]          cmt_kind,
  output logic [SEQ_W-1:0]    cmt_seq,
  output logic                cmt_to_sb,
  input  logic                barrier_set,
  input  logic [SEQ_W-1:0]    barrier_set_seq,
  input  logic                barrier_done,
  input  logic [SEQ_W-1:0]    barrier_done_seq,
  output logic [SEQ_W-1:0]    last_barrier,
  output logic                retry_pending
);
  localparam int IE_W  = 2 + STREAM_W + SEQ_W;
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

  // issue queue
  logic            iq_empty, iq_full, iq_push, iq_pop;
  logic [IE_W-1:0] iq_head;

  assign req_ready = !iq_full;
  assign iq_push   = req_valid && !iq_full;

  lsq_ring #(.W(IE_W), .DEPTH(IQ_DEPTH)) u_iq (
    .clk(clk), .rst_n(rst_n),
    .push(iq_push), .din({req_kind, req_stream, req_seq}),
    .pop(iq_pop), .dout(iq_head), .empty(iq_empty), .full(iq_full)
  );

  acc_kind_e           h_kind;
  logic [STREAM_W-1:0] h_stream;
  logic [SEQ_W-1:0]    h_seq;
  assign h_kind   = acc_kind_e'(iq_head[IE_W-1 -: 2]);
  assign h_stream = iq_head[SEQ_W +: STREAM_W];
  assign h_seq    = iq_head[SEQ_W-1:0];

  // port state and in-flight accounting
  port_state_e      state_q;
  logic [CNT_W-1:0] inflight_q;
  logic             xq_full, xq_empty, xq_head_done, resp_counted;
  logic [1:0]       xq_head_kind;
  logic             nonspec, limit_ok, want_mem, pass_kind;
  logic             mem_accept, pass_now, advance, inc, dec;

  assign nonspec  = (h_seq == head_seq) && (h_stream == cur_stream);
  assign limit_ok = inflight_q < CNT_W'(MAX_INFLIGHT);

  always_comb begin
    want_mem  = 1'b0;
    pass_kind = 1'b0;
    unique case (h_kind)
      ACC_LOAD:  want_mem  = 1'b1;
      ACC_OTHER: want_mem  = nonspec && limit_ok;
      default:   pass_kind = 1'b1;
    endcase
  end

  assign mem_valid  = !iq_empty && !xq_full && (state_q == PORT_RUN) && want_mem;
  assign mem_accept = mem_valid && mem_ready;
  assign pass_now   = !iq_empty && !xq_full && (state_q == PORT_RUN) && pass_kind;
  assign advance    = mem_accept || pass_now;
  assign iq_pop     = advance;
  assign mem_kind   = h_kind;
  assign mem_seq    = h_seq;

  assign inc = mem_accept && (h_kind == ACC_OTHER);
  assign dec = resp_valid && resp_counted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PORT_RUN;
      inflight_q <= '0;
    end else begin
      unique case (state_q)
        PORT_RUN:  if (mem_valid && !mem_ready) state_q <= PORT_WAIT;
        PORT_WAIT: if (mem_retry)               state_q <= PORT_RUN;
        default:                                state_q <= PORT_RUN;
      endcase
      inflight_q <= inflight_q + CNT_W'(inc) - CNT_W'(dec);
    end
  end

  assign retry_pending = (state_q == PORT_WAIT);

  // transfer queue
  lsq_xfer_queue #(.SEQ_W(SEQ_W), .DEPTH(XQ_DEPTH), .TAG_W(TAG_W)) u_xq (
    .clk(clk), .rst_n(rst_n),
    .push(advance), .push_seq(h_seq), .push_kind(h_kind),
    .push_done(pass_kind), .push_counted(h_kind == ACC_OTHER),
    .alloc_tag(mem_tag),
    .mark(resp_valid), .mark_tag(resp_tag), .mark_counted(resp_counted),
    .pop(cmt_pop && cmt_valid),
    .head_seq(cmt_seq), .head_kind(xq_head_kind), .head_done(xq_head_done),
    .empty(xq_empty), .full(xq_full)
  );

  assign cmt_valid = !xq_empty && xq_head_done;
  assign cmt_kind  = xq_head_kind;
  assign cmt_to_sb = (xq_head_kind == ACC_STORE);

  lsq_barrier_reg #(.SEQ_W(SEQ_W)) u_bar (
    .clk(clk), .rst_n(rst_n),
    .set(barrier_set), .set_seq(barrier_set_seq),
    .done(barrier_done), .done_seq(barrier_done_seq),
    .last(last_barrier)
  );
endmodule

// File: rtl/lsq_issue_ctrl_chk.sv
module lsq_issue_ctrl_chk #(
  parameter int SEQ_W        = 8,
  parameter int MAX_INFLIGHT = 2,
  parameter int CNT_W        = 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [1:0]       mem_kind,
  input logic [SEQ_W-1:0] mem_seq,
  input logic [SEQ_W-1:0] head_seq,
  input logic             mem_retry,
  input logic             retry_pending,
  input logic             cmt_valid,
  input logic             cmt_pop,
  input logic [SEQ_W-1:0] cmt_seq,
  input logic             barrier_set,
  input logic             barrier_done,
  input logic [SEQ_W-1:0] barrier_done_seq,
  input logic [SEQ_W-1:0] last_barrier,
  input logic [CNT_W-1:0] inflight
);
  // R7
  retry_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pending |-> !mem_valid);
  // R7
  reject_enters_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> retry_pending);
  // R7
  retry_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_pending && mem_retry) |=> !retry_pending);
  // R4
  no_store_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_kind == 2'd0 || mem_kind == 2'd2));
  // R5
  other_nonspec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_kind == 2'd2) |-> (mem_seq == head_seq));
  // R6
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(MAX_INFLIGHT));
  // R8
  cmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_pop) |=> (cmt_valid && $stable(cmt_seq)));
  // R9
  barrier_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier_done && !barrier_set && barrier_done_seq == last_barrier) |=> (last_barrier == '0));
endmodule

bind lsq_issue_ctrl lsq_issue_ctrl_chk #(
  .SEQ_W(SEQ_W), .MAX_INFLIGHT(MAX_INFLIGHT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
  .mem_seq(mem_seq), .head_seq(head_seq), .mem_retry(mem_retry),
  .retry_pending(retry_pending),
  .cmt_valid(cmt_valid), .cmt_pop(cmt_pop), .cmt_seq(cmt_seq),
  .barrier_set(barrier_set), .barrier_done(barrier_done),
  .barrier_done_seq(barrier_done_seq), .last_barrier(last_barrier),
  .inflight(inflight_q)
);

// File: tb/lsq_issue_ctrl_test.sv
module lsq_issue_ctrl_test;
  localparam int PERIOD   = 10;
  localparam int SEQ_W    = 8;
  localparam int STREAM_W = 4;
  localparam int TAG_W    = 2;
  localparam logic [1:0] K_LOAD = 2'd0, K_STORE = 2'd1, K_OTHER = 2'd2, K_NOP = 2'd3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [SEQ_W-1:0] req_seq = 0, head_seq = 0;
  logic [STREAM_W-1:0] req_stream = 0, cur_stream = 1;
  logic mem_valid, mem_ready = 1, mem_retry = 0;
  logic [1:0] mem_kind;
  logic [SEQ_W-1:0] mem_seq;
  logic [TAG_W-1:0] mem_tag, resp_tag = 0;
  logic resp_valid = 0;
  logic cmt_valid, cmt_pop = 0, cmt_to_sb;
  logic [1:0] cmt_kind;
  logic [SEQ_W-1:0] cmt_seq;
  logic barrier_set = 0, barrier_done = 0;
  logic [SEQ_W-1:0] barrier_set_seq = 0, barrier_done_seq = 0, last_barrier;
  logic retry_pending;

  always #(PERIOD/2) clk = ~clk;

  lsq_issue_ctrl #(.SEQ_W(SEQ_W), .STREAM_W(STREAM_W), .IQ_DEPTH(4),
                   .XQ_DEPTH(4), .MAX_INFLIGHT(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_seq(req_seq), .req_stream(req_stream),
    .head_seq(head_seq), .cur_stream(cur_stream),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
    .mem_seq(mem_seq), .mem_tag(mem_tag), .mem_retry(mem_retry),
    .resp_valid(resp_valid), .resp_tag(resp_tag),
    .cmt_valid(cmt_valid), .cmt_pop(cmt_pop), .cmt_kind(cmt_kind),
    .cmt_seq(cmt_seq), .cmt_to_sb(cmt_to_sb),
    .barrier_set(barrier_set), .barrier_set_seq(barrier_set_seq),
    .barrier_done(barrier_done), .barrier_done_seq(barrier_done_seq),
    .last_barrier(last_barrier), .retry_pending(retry_pending)
  );

  int n_chk = 0, n_bad = 0;
  int accepts = 0;
  logic resp_hold = 0, auto_pop = 1;
  logic [TAG_W-1:0] pend_q[$];
  logic [SEQ_W+1:0] exp_q[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes the expected commit item once the request is taken
  task automatic send(input logic [1:0] k, input logic [SEQ_W-1:0] s, input logic [STREAM_W-1:0] st);
    @(negedge clk);
    req_kind = k; req_seq = s; req_stream = st; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back({k, s});
    @(posedge clk); #1 req_valid = 0;
  endtask

  // memory responder and commit monitor
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (pend_q.size() > 0 && !resp_hold) begin
        resp_valid = 1; resp_tag = pend_q.pop_front();
      end else resp_valid = 0;
      if (mem_valid && mem_ready) begin
        pend_q.push_back(mem_tag);
        accepts++;
      end
      cmt_pop = auto_pop && cmt_valid;
      if (cmt_pop) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected commit", cmt_seq, -1);
        else begin
          logic [SEQ_W+1:0] e;
          e = exp_q.pop_front();
          // R8 order, R4 store flag
          chk(cmt_seq == e[SEQ_W-1:0] && cmt_kind == e[SEQ_W+1:SEQ_W], "R8 commit order",
              int'({cmt_kind, cmt_seq}), int'(e));
          chk(cmt_to_sb == (e[SEQ_W+1:SEQ_W] == K_STORE), "R4 store flag", cmt_to_sb,
              e[SEQ_W+1:SEQ_W] == K_STORE);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    cyc(3); #3;
    // R1 reset state
    chk(req_ready && !mem_valid && !cmt_valid && !retry_pending && last_barrier == 0,
        "R1 reset", {req_ready, mem_valid, cmt_valid, retry_pending}, 4'b1000);
    rst_n = 1;
    cyc(2);

    // R3 R4: speculative loads, bypassing stores and failed predicates
    base = accepts;
    send(K_LOAD, 1, 0); send(K_STORE, 2, 0); send(K_NOP, 3, 0);
    send(K_LOAD, 4, 0); send(K_STORE, 5, 0);
    cyc(20); #3;
    chk(accepts == base + 2, "R3 loads only to memory", accepts - base, 2);
    chk(exp_q.size() == 0, "R4 all committed", exp_q.size(), 0);

    // R5: other access waits for head and stream match
    base = accepts;
    head_seq = 0;
    send(K_OTHER, 10, 1);
    cyc(5); #3;
    chk(!mem_valid && accepts == base, "R5 stall seq mismatch", mem_valid, 0);
    @(negedge clk); head_seq = 10; cur_stream = 2;
    cyc(4); #3;
    chk(!mem_valid && accepts == base, "R5 stall stream mismatch", mem_valid, 0);
    @(negedge clk); cur_stream = 1;
    cyc(10); #3;
    chk(accepts == base + 1 && exp_q.size() == 0, "R5 issues when nonspec", accepts - base, 1);

    // R6: in-flight limit
    base = accepts;
    resp_hold = 1;
    send(K_OTHER, 20, 1); send(K_OTHER, 21, 1); send(K_OTHER, 22, 1);
    @(negedge clk); head_seq = 20; cyc(4);
    head_seq = 21; cyc(4);
    head_seq = 22; cyc(4); #3;
    chk(!mem_valid && accepts == base + 2, "R6 limit holds", accepts - base, 2);
    @(negedge clk); resp_hold = 0;
    cyc(15); #3;
    chk(accepts == base + 3 && exp_q.size() == 0, "R6 resumes", accepts - base, 3);

    // R7: reject, retry, same request first
    @(negedge clk); mem_ready = 0;
    send(K_LOAD, 30, 0); send(K_STORE, 31, 0);
    cyc(2); #3;
    chk(retry_pending == 1, "R7 enters retry", retry_pending, 1);
    @(negedge clk); mem_ready = 1;
    cyc(3); #3;
    chk(!mem_valid && retry_pending, "R7 silent while waiting", mem_valid, 0);
    @(negedge clk); mem_retry = 1;
    @(negedge clk); mem_retry = 0; #3;
    chk(!retry_pending && mem_valid && mem_seq == 30, "R7 same request again", mem_seq, 30);
    cyc(10); #3;
    chk(exp_q.size() == 0, "R7 order kept", exp_q.size(), 0);

    // R2: issue queue full
    @(negedge clk); head_seq = 0;
    send(K_OTHER, 40, 1); send(K_LOAD, 41, 0); send(K_LOAD, 42, 0); send(K_LOAD, 43, 0);
    cyc(2); #3;
    chk(req_ready == 0, "R2 full queue not ready", req_ready, 0);
    @(negedge clk); head_seq = 40;
    cyc(15); #3;
    chk(req_ready == 1 && exp_q.size() == 0, "R2 drains", req_ready, 1);

    // R8: explicit pop and head-only offer
    @(negedge clk); auto_pop = 0;
    send(K_STORE, 50, 0);
    cyc(4); #3;
    chk(cmt_valid && cmt_seq == 50, "R8 offered", cmt_seq, 50);
    cyc(3); #3;
    chk(cmt_valid && cmt_seq == 50, "R8 held without pop", cmt_seq, 50);
    @(negedge clk); auto_pop = 1;
    cyc(4);
    resp_hold = 1;
    send(K_LOAD, 51, 0); send(K_STORE, 52, 0);
    cyc(4); #3;
    chk(!cmt_valid, "R8 store waits behind load", cmt_valid, 0);
    @(negedge clk); resp_hold = 0;
    cyc(10); #3;
    chk(exp_q.size() == 0, "R3 load completes on response", exp_q.size(), 0);

    // R9: barrier register
    @(negedge clk); barrier_set = 1; barrier_set_seq = 10;
    @(negedge clk); barrier_set = 0; #3;
    chk(last_barrier == 10, "R9 set", last_barrier, 10);
    @(negedge clk); barrier_set = 1; barrier_set_seq = 20;
    @(negedge clk); barrier_set = 0; barrier_done = 1; barrier_done_seq = 10;
    @(negedge clk); barrier_done = 0; #3;
    chk(last_barrier == 20, "R9 stale done ignored", last_barrier, 20);
    @(negedge clk); barrier_done = 1; barrier_done_seq = 20;
    @(negedge clk); barrier_done = 0; #3;
    chk(last_barrier == 0, "R9 matching done clears", last_barrier, 0);
    @(negedge clk); barrier_set = 1; barrier_set_seq = 33; barrier_done = 1; barrier_done_seq = 0;
    @(negedge clk); barrier_set = 0; barrier_done = 0; #3;
    chk(last_barrier == 33, "R9 set wins", last_barrier, 33);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule